// File: doc/BRIEF.md
# BCH Syndrome Error Locator

This block takes the syndrome set that a flash controller has already computed for one protected block. It returns how many bit errors the block holds and the bit index of each one. The data bytes are never presented to it. A protected block is at most 1023 bytes: 512 bytes of payload, plus parity and an optional spare field. An error can sit at any bit of that span, including bits inside the parity. Arithmetic is in GF(2^13) with primitive polynomial x^13+x^4+x^3+x+1. This field gives 13-bit positions, enough for 8184 bits.

A decode starts with a one-cycle `start` pulse. Three correction strengths can be chosen per decode. The block first runs an inversionless Berlekamp–Massey solver, one iteration per clock, to build the error-locator polynomial. It then runs a serial Chien search that tests one candidate bit position per clock. If the locator degree exceeds the chosen strength, the decode is declared uncorrectable. It is also declared uncorrectable if the number of roots found does not match the degree. On success, the error count is reported and each location can be read back by index.

Top module: `bch_error_locator`

## Requirements
- R1: The 2-bit `level` input is captured with an accepted start and selects the correction strength t: 0 gives 4, 1 gives 8, and 2 or 3 give 16.
- R2: Syndrome lane j, bits [13j+12:13j] of `syndromes`, carries S(j+1) = XOR over all errors at bit index p of alpha^((j+1)·p). Lanes 0 to 2t−1 are used, and lanes at 2t and above have no effect on the result.
- R3: An all-zero syndrome set yields an error count of 0 with `uncorrectable` low.
- R4: For 1 to t errors at distinct bit indices below NBITS, `err_count` equals the number of errors and `uncorrectable` is low.
- R5: After a successful decode, `loc_pos` for `loc_idx` = k gives the k-th error bit index in ascending order. This includes index 0 and index NBITS−1.
- R6: When the errors exceed t (the locator degree is above t, or the root count differs from the degree), `uncorrectable` is high and `err_count` is 0.
- R7: A `start` that arrives while `busy` is high is ignored, and the running decode completes with its own result.
- R8: `done` is high for exactly one cycle, in the cycle where the result outputs first show the new values. `busy` is low in that cycle, and a `start` given in that same cycle is accepted.
- R9: After reset, `busy`, `done`, `uncorrectable` and `err_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a decode when idle |
| level | input | 2 | Correction strength select |
| syndromes | input | 2·TMAX·13 | Packed syndrome lanes S1 upward |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle result-ready pulse |
| err_count | output | clog2(TMAX+1) | Number of located errors |
| uncorrectable | output | 1 | Error count beyond the chosen strength |
| loc_idx | input | clog2(TMAX) | Location readout index |
| loc_pos | output | clog2(NBITS) | Bit index of the selected location |

## Verification
Result delivery and acceptance of the next decode can fall in the same cycle. The completion pulse drops `busy`, and a new `start` may be presented on that very cycle. The bench drives `start` with fresh syndromes at the sample point where it first sees `done` high. It then requires `done` to be gone and `busy` to be set one cycle later. It also requires both the delivered count and the following decode's count and locations to match values computed from its own exponent table. A separate case pulses `start` in the middle of a run to confirm the pulse is not taken.

// File: rtl/bch_gf_pkg.sv
// Package: GF(2^13) arithmetic shared by the locator stages.
// Assumes polynomial basis, primitive polynomial x^13+x^4+x^3+x+1.
package bch_gf_pkg;
    localparam int GF_M = 13;
    localparam logic [GF_M:0] GF_POLY = 14'h201B;

    typedef logic [GF_M-1:0] gf_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SOLVE, ST_SEARCH} loc_state_e;

    // Field product by shift-and-reduce, most significant bit of b first.
    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        logic [GF_M:0] acc;
        acc = '0;
        for (int k = GF_M - 1; k >= 0; k--) begin
            acc = {acc[GF_M-1:0], 1'b0};
            if (acc[GF_M]) acc = acc ^ GF_POLY;
            if (b[k]) acc = acc ^ {1'b0, a};
        end
        return acc[GF_M-1:0];
    endfunction

    // alpha^(-n) by repeated division by alpha; used for constants only.
    function automatic gf_t gf_alpha_neg_pow(input int n);
        logic [GF_M:0] v;
        v = 14'd1;
        for (int k = 0; k < n; k++) begin
            if (v[0]) v = v ^ GF_POLY;
            v = v >> 1;
        end
        return v[GF_M-1:0];
    endfunction
endpackage

// File: rtl/bch_bm_solver.sv
// Inversionless Berlekamp-Massey solver: one iteration per clock,
// 2t iterations in all. Assumes syn and t_val stay stable while running.
// Locator coefficients above TMAX are dropped; that only happens when
// the degree already exceeds t, which the caller flags as uncorrectable.
module bch_bm_solver
    import bch_gf_pkg::*;
#(
    parameter int TMAX = 16,
    localparam int CW = $clog2(TMAX + 1),
    localparam int RW = $clog2(2 * TMAX),
    localparam int DW = $clog2(2 * TMAX + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic [CW-1:0]                t_val,
    input  logic [2*TMAX*GF_M-1:0]       syn,
    output logic [(TMAX+1)*GF_M-1:0]     lambda_o,
    output logic [DW-1:0]                deg_o,
    output logic                         fin
);
    gf_t           lane_w [2*TMAX];
    gf_t           lam    [TMAX+1];
    gf_t           bb     [TMAX+1];
    gf_t           gam;
    gf_t           delta;
    logic [DW-1:0] deg;
    logic [RW-1:0] r;
    logic          running;

    for (genvar g = 0; g < 2 * TMAX; g++) begin : g_lane
        assign lane_w[g] = syn[g*GF_M +: GF_M];
    end

    for (genvar g = 0; g <= TMAX; g++) begin : g_out
        assign lambda_o[g*GF_M +: GF_M] = lam[g];
    end

    assign deg_o = deg;

    // Discrepancy of iteration r: sum of lambda_i * S(r+1-i).
    always_comb begin
        delta = '0;
        for (int i = 0; i <= TMAX; i++) begin
            if (i <= int'(r)) delta = delta ^ gf_mul(lam[i], lane_w[r - RW'(i)]);
        end
    end

    // One solver iteration per cycle; load the initial state on go.
    always_ff @(posedge clk) begin
        fin <= 1'b0;
        if (!rst_n) begin
            running <= 1'b0;
            r       <= '0;
            deg     <= '0;
            gam     <= '0;
            for (int i = 0; i <= TMAX; i++) begin
                lam[i] <= '0;
                bb[i]  <= '0;
            end
        end else if (go) begin
            running <= 1'b1;
            r       <= '0;
            deg     <= '0;
            gam     <= gf_t'(1);
            for (int i = 0; i <= TMAX; i++) begin
                lam[i] <= (i == 0) ? gf_t'(1) : '0;
                bb[i]  <= (i == 0) ? gf_t'(1) : '0;
            end
        end else if (running) begin
            lam[0] <= gf_mul(gam, lam[0]);
            for (int i = 1; i <= TMAX; i++)
                lam[i] <= gf_mul(gam, lam[i]) ^ gf_mul(delta, bb[i-1]);
            if (delta != '0 && 2 * int'(deg) <= int'(r)) begin
                for (int i = 0; i <= TMAX; i++) bb[i] <= lam[i];
                deg <= DW'(int'(r) + 1 - int'(deg));
                gam <= delta;
            end else begin
                bb[0] <= '0;
                for (int i = 1; i <= TMAX; i++) bb[i] <= bb[i-1];
            end
            r <= r + 1'b1;
            if (int'(r) == 2 * int'(t_val) - 1) begin
                running <= 1'b0;
                fin     <= 1'b1;
            end
        end
    end

    AST_DEG_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        running && !go |=> deg >= $past(deg)); // R4
endmodule

// File: rtl/bch_chien_search.sv
// Serial Chien search: evaluates the locator at alpha^(-p) for
// p = 0 .. NBITS-1, one position per clock, and logs the roots in
// ascending order. Assumes lambda_i is stable in the cycle go is high.
module bch_chien_search
    import bch_gf_pkg::*;
#(
    parameter int TMAX  = 16,
    parameter int NBITS = 8184,
    localparam int PW = $clog2(NBITS),
    localparam int IW = $clog2(TMAX),
    localparam int NW = $clog2(TMAX + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic [(TMAX+1)*GF_M-1:0] lambda_i,
    input  logic [IW-1:0]            loc_idx,
    output logic [PW-1:0]            loc_pos,
    output logic [NW-1:0]            roots,
    output logic                     fin
);
    gf_t           cell_w [TMAX+1];
    gf_t           sum;
    logic [PW-1:0] pos;
    logic [PW-1:0] locs [TMAX];
    logic          running;
    logic          hit;

    for (genvar g = 0; g <= TMAX; g++) begin : g_cell
        localparam gf_t STEP = gf_alpha_neg_pow(g);
        gf_t cell_q;
        // Term g advances by alpha^(-g) each position.
        always_ff @(posedge clk) begin
            if (!rst_n)       cell_q <= '0;
            else if (go)      cell_q <= lambda_i[g*GF_M +: GF_M];
            else if (running) cell_q <= gf_mul(cell_q, STEP);
        end
        assign cell_w[g] = cell_q;
    end

    // Locator value at the current position.
    always_comb begin
        sum = '0;
        for (int g = 0; g <= TMAX; g++) sum = sum ^ cell_w[g];
    end

    assign hit     = running && (sum == '0);
    assign loc_pos = locs[loc_idx];

    // Position sweep, root counting (saturating at TMAX+1) and logging.
    always_ff @(posedge clk) begin
        fin <= 1'b0;
        if (!rst_n) begin
            running <= 1'b0;
            pos     <= '0;
            roots   <= '0;
            for (int k = 0; k < TMAX; k++) locs[k] <= '0;
        end else if (go) begin
            running <= 1'b1;
            pos     <= '0;
            roots   <= '0;
        end else if (running) begin
            if (hit) begin
                if (int'(roots) < TMAX) locs[roots[IW-1:0]] <= pos;
                if (int'(roots) <= TMAX) roots <= roots + 1'b1;
            end
            pos <= pos + 1'b1;
            if (pos == PW'(NBITS - 1)) begin
                running <= 1'b0;
                fin     <= 1'b1;
            end
        end
    end

    AST_POS_IN_CODEWORD: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> int'(pos) < NBITS); // R5
    AST_ROOTS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(roots) <= TMAX + 1); // R6
endmodule

// File: rtl/bch_error_locator.sv
// Top: sequences the solver and the search. It captures the syndromes
// and the strength on an accepted start, and publishes the count and
// the uncorrectable flag together with a one-cycle done.
// Assumes the strengths TMAX/4, TMAX/2 and TMAX (4, 8, 16 by default).
module bch_error_locator
    import bch_gf_pkg::*;
#(
    parameter int TMAX  = 16,
    parameter int NBITS = 8184,
    localparam int CW = $clog2(TMAX + 1),
    localparam int IW = $clog2(TMAX),
    localparam int PW = $clog2(NBITS),
    localparam int SW = 2 * TMAX * GF_M,
    localparam int DW = $clog2(2 * TMAX + 1),
    localparam int NW = $clog2(TMAX + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    level,
    input  logic [SW-1:0] syndromes,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] err_count,
    output logic          uncorrectable,
    input  logic [IW-1:0] loc_idx,
    output logic [PW-1:0] loc_pos
);
    loc_state_e              st;
    logic [CW-1:0]           t_q;
    logic [SW-1:0]           syn_q;
    logic [(TMAX+1)*GF_M-1:0] lambda_w;
    logic [DW-1:0]           deg_w;
    logic [NW-1:0]           roots_w;
    logic                    bm_go, bm_fin, ch_go, ch_fin, accept;

    assign busy   = (st != ST_IDLE);
    assign accept = start && (st == ST_IDLE);
    assign bm_go  = accept;
    assign ch_go  = (st == ST_SOLVE) && bm_fin && (int'(deg_w) <= int'(t_q));

    bch_bm_solver #(.TMAX(TMAX)) u_solver (
        .clk(clk), .rst_n(rst_n), .go(bm_go), .t_val(t_q), .syn(syn_q),
        .lambda_o(lambda_w), .deg_o(deg_w), .fin(bm_fin)
    );

    bch_chien_search #(.TMAX(TMAX), .NBITS(NBITS)) u_search (
        .clk(clk), .rst_n(rst_n), .go(ch_go), .lambda_i(lambda_w),
        .loc_idx(loc_idx), .loc_pos(loc_pos), .roots(roots_w), .fin(ch_fin)
    );

    // Phase control, input capture and result publication.
    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (!rst_n) begin
            st            <= ST_IDLE;
            t_q           <= '0;
            syn_q         <= '0;
            err_count     <= '0;
            uncorrectable <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    syn_q <= syndromes;
                    t_q   <= (level == 2'd0) ? CW'(TMAX / 4) :
                             (level == 2'd1) ? CW'(TMAX / 2) : CW'(TMAX);
                    st    <= ST_SOLVE;
                end
                ST_SOLVE: if (bm_fin) begin
                    if (ch_go) begin
                        st <= ST_SEARCH;
                    end else begin
                        st            <= ST_IDLE;
                        done          <= 1'b1;
                        err_count     <= '0;
                        uncorrectable <= 1'b1;
                    end
                end
                ST_SEARCH: if (ch_fin) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                    if (int'(roots_w) == int'(deg_w)) begin
                        err_count     <= CW'(roots_w);
                        uncorrectable <= 1'b0;
                    end else begin
                        err_count     <= '0;
                        uncorrectable <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(err_count) && $stable(uncorrectable)); // R8
    AST_COUNT_WITHIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        done && !uncorrectable |-> err_count <= t_q); // R4
endmodule

// File: tb/bch_error_locator_tb.sv
module bch_error_locator_tb;
    localparam int TMAX  = 16;
    localparam int NBITS = 1023;
    localparam int M     = 13;
    localparam int ORD   = 8191;
    localparam int CW = $clog2(TMAX + 1);
    localparam int IW = $clog2(TMAX);
    localparam int PW = $clog2(NBITS);
    localparam int SW = 2 * TMAX * M;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    level = 2'd0;
    logic [SW-1:0] syn_bus = '0;
    logic          busy, done, uncorrectable;
    logic [CW-1:0] err_count;
    logic [IW-1:0] loc_idx = '0;
    logic [PW-1:0] loc_pos;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    int gexp [ORD];
    int err_pos [32];
    int n_err = 0;

    always #5 clk = ~clk;

    bch_error_locator #(.TMAX(TMAX), .NBITS(NBITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .level(level),
        .syndromes(syn_bus), .busy(busy), .done(done), .err_count(err_count),
        .uncorrectable(uncorrectable), .loc_idx(loc_idx), .loc_pos(loc_pos)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int t_of(input int lv);
        return (lv == 0) ? 4 : (lv == 1) ? 8 : 16;
    endfunction

    // Build syndromes from err_pos; lanes above 2t carry junk if asked.
    task automatic prep(input int lv, input bit junk);
        int t;
        t = t_of(lv);
        level = 2'(lv);
        syn_bus = '0;
        for (int j = 1; j <= 2 * TMAX; j++) begin
            logic [M-1:0] s;
            s = '0;
            if (j <= 2 * t) begin
                for (int e = 0; e < n_err; e++) s = s ^ M'(gexp[(j * err_pos[e]) % ORD]);
            end else if (junk) begin
                s = M'(j * 389 + 77);
            end
            syn_bus[(j-1)*M +: M] = s;
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int w;
        w = 0;
        while (!done) begin
            @(negedge clk);
            w++;
            if (w > 60000) begin
                chk(1'b0, "R8 watchdog on done", 0, 1);
                break;
            end
        end
    endtask

    // Called at the sample point where done is high.
    task automatic check_result(input bit exp_unc, input string req);
        int srt [32];
        chk(uncorrectable == exp_unc, {req, " uncorrectable"}, int'(uncorrectable), int'(exp_unc));
        chk(int'(err_count) == (exp_unc ? 0 : n_err), {req, " count"}, int'(err_count), exp_unc ? 0 : n_err);
        if (!exp_unc) begin
            for (int k = 0; k < n_err; k++) srt[k] = err_pos[k];
            for (int a = 0; a < n_err; a++)
                for (int b = 0; b + 1 < n_err - a; b++)
                    if (srt[b] > srt[b+1]) begin
                        int tmp;
                        tmp = srt[b]; srt[b] = srt[b+1]; srt[b+1] = tmp;
                    end
            for (int k = 0; k < n_err; k++) begin
                loc_idx = IW'(k);
                #1;
                chk(int'(loc_pos) == srt[k], "R5 location", int'(loc_pos), srt[k]);
                @(negedge clk);
            end
        end
    endtask

    task automatic run(input int lv, input bit junk, input bit exp_unc, input string req);
        prep(lv, junk);
        pulse_start();
        wait_done();
        check_result(exp_unc, req);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                chk(1'b0, "watchdog expired", cycles, 190000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int e;
        e = 1;
        for (int k = 0; k < ORD; k++) begin
            gexp[k] = e;
            e = e << 1;
            if (e & 32'h2000) e = e ^ 32'h201B;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9 busy/done at reset", int'(busy) + 2 * int'(done), 0);
        chk(err_count == '0 && uncorrectable == 1'b0, "R9 result at reset", int'(err_count), 0);

        n_err = 0;                                   run(0, 1'b0, 1'b0, "R3 zero syndromes");
        n_err = 1; err_pos[0] = 0;                   run(0, 1'b0, 1'b0, "R5 first bit");
        n_err = 1; err_pos[0] = NBITS - 1;           run(0, 1'b0, 1'b0, "R5 last bit");
        n_err = 4; err_pos[0] = 511; err_pos[1] = 3; err_pos[2] = 1000; err_pos[3] = 100;
        run(0, 1'b0, 1'b0, "R4 four errors t4");
        n_err = 5; err_pos[4] = 777;                 run(0, 1'b0, 1'b1, "R6 five errors t4");
        n_err = 3; err_pos[0] = 12; err_pos[1] = 640; err_pos[2] = 901;
        run(0, 1'b1, 1'b0, "R2 junk upper lanes");

        n_err = 8;
        for (int k = 0; k < 8; k++) err_pos[k] = (k * 131 + 17) % NBITS;
        run(1, 1'b0, 1'b0, "R1 level 1 eight errors");
        run(0, 1'b0, 1'b1, "R1 level 0 eight errors");
        n_err = 9; err_pos[8] = 1010;                run(1, 1'b0, 1'b1, "R6 nine errors t8");
        n_err = 16;
        for (int k = 0; k < 16; k++) err_pos[k] = (k * 61 + 5) % NBITS;
        run(2, 1'b0, 1'b0, "R1 level 2 sixteen errors");
        run(3, 1'b0, 1'b0, "R1 level 3 sixteen errors");
        n_err = 17; err_pos[16] = 1020;              run(3, 1'b0, 1'b1, "R6 seventeen errors t16");

        // R7: a start while busy must not disturb the running decode.
        n_err = 2; err_pos[0] = 10; err_pos[1] = 20;
        prep(0, 1'b0);
        pulse_start();
        repeat (5) @(negedge clk);
        chk(busy == 1'b1, "R7 busy during run", int'(busy), 1);
        level = 2'd2;
        syn_bus = {SW/32{32'hA5C3_1E77}};
        pulse_start();
        wait_done();
        check_result(1'b0, "R7 start while busy");
        @(negedge clk);
        chk(busy == 1'b0, "R7 no restart", int'(busy), 0);

        // R8: start in the cycle done is high.
        n_err = 2; err_pos[0] = 300; err_pos[1] = 44;
        prep(1, 1'b0);
        pulse_start();
        wait_done();
        chk(int'(err_count) == 2 && !uncorrectable, "R8 first result", int'(err_count), 2);
        n_err = 3; err_pos[0] = 2; err_pos[1] = 1001; err_pos[2] = 555;
        prep(0, 1'b0);
        pulse_start();
        chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
        chk(busy == 1'b1, "R8 start taken at done", int'(busy), 1);
        wait_done();
        check_result(1'b0, "R8 chained decode");

        // R4 sweep: error pairs across the block at every level.
        for (int k = 0; k < 40; k++) begin
            n_err = 2;
            err_pos[0] = (k * 53) % NBITS;
            err_pos[1] = (k * 53 + 517) % NBITS;
            run(k % 3, 1'b0, 1'b0, "R4 pair sweep");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule